// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller

This block gathers interrupt requests for a small multiprocessor and presents each CPU with one line per priority level, 1 to 15. It has two register banks. The shared master bank records the level of every system interrupt source. It also holds a disable mask and a selector that names the one CPU receiving system interrupts. Each CPU slice holds a private pending word: software-interrupt bits in the upper half, a level-15 bit and a local timer bit.

Both banks are reached through a 32-bit register bus that carries a byte address. Software addresses a CPU slice by placing its number on a select input. Bits [1:0] of the address must be zero. The word index is the address shifted right by two.

Every cycle the block rebuilds a 16-bit priority vector for each CPU and loads it into a register that drives that CPU's output lines. System sources first pass the disable mask. Each surviving source is then mapped to a fixed level on the target CPU. The CPU's software bits are shifted down by 16, and its level-15 and timer bits are added unless the global master-disable bit is set.

Top module: `intc_top`

## Requirements
- R1: After reset the system pending, disable, target and every CPU pending register read as zero, and every output line is low.
- R2: A CPU-slice write to word 1 clears the pending bits set in the written value, limited to bits [31:17] and bit 15. Bit 14 (timer) and all other bits are unaffected.
- R3: A CPU-slice write to word 2 sets the pending bits of the written value within bits [31:17]. Every other written bit is ignored.
- R4: A master write to word 2 clears the disable bits set in the written value. The value is limited to the valid mask: bits [NUM_SRC-1:0] plus bit 31.
- R5: A master write to word 3 sets the disable bits set in the written value, limited to the same valid mask. The system pending register is not changed.
- R6: A master write to word 4 loads the target CPU with the written value ANDed with NUM_CPUS-1.
- R7: System pending bit s is the level of system input s, captured one clock after the input. When that pending bit is set and disable bit s is clear, output level (s mod 15)+1 is asserted on the target CPU only.
- R8: A CPU's level-15 pending bit drives its level 15, and its timer pending bit drives its level 14, only while disable bit 31 is clear.
- R9: CPU pending bit b, for b in 17..31, drives output level b-16 of that CPU.
- R10: The timer pending bit of CPU i follows timer input i one clock later. A high level-15 input for CPU i sets its level-15 pending bit, which stays set until a word-1 clear. If that input is high in the same cycle as the clear, the bit stays set.
- R11: Output bit i*15+(L-1) is level L of CPU i. No level-0 line exists. Each output is registered and changes one clock after the register state it is derived from.
- R12: The block has these reads: master word 0 returns pending, word 1 returns disable, word 4 returns target, and CPU word 0 returns that slice's pending word. Writes to any other word, or with address bits [1:0] nonzero, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysIrq | input | NUM_SRC | System interrupt source levels |
| timerIrq | input | NUM_CPUS | Per-CPU local timer request levels |
| lvl15Irq | input | NUM_CPUS | Per-CPU level-15 set requests |
| mWe | input | 1 | Master bank write strobe |
| mAddr | input | ADDR_W | Master bank byte address |
| mWdata | input | 32 | Master bank write data |
| mRdata | output | 32 | Master bank read data |
| cWe | input | 1 | CPU slice write strobe |
| cSel | input | CPU_W | CPU slice selected for access |
| cAddr | input | ADDR_W | CPU slice byte address |
| cWdata | input | 32 | CPU slice write data |
| cRdata | output | 32 | CPU slice read data |
| irlOut | output | NUM_CPUS*15 | Registered priority lines, levels 1..15 per CPU |

## Verification
On every cycle the assertions check the register side of the block. They cover the set and clear effects of each write, with their masks. They also check that the pending register follows the system inputs and the timer inputs, and that ignored writes leave disable and target untouched. The bench's sweeps alone show the mapped output behaviour. These sweeps cover the source-to-level mapping for every source and every target CPU, and the software-bit shift. They also cover the gating by master disable, masking that keeps pending state, and the one-cycle output register.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W     = 16;
  localparam int LVL15_BIT = 15;
  localparam int TIMER_BIT = 14;
  localparam int MDIS_BIT  = 31;
  localparam logic [31:0] SOFT_MASK = 32'hFFFE_0000;
  localparam logic [31:0] CLR_MASK  = SOFT_MASK | (32'd1 << LVL15_BIT);

  typedef struct packed {
    logic mEnable;
    logic mDisable;
    logic mTarget;
    logic cClear;
    logic cSet;
  } strobes_t;

  typedef enum logic [1:0] {
    M_RD_NONE,
    M_RD_PEND,
    M_RD_DIS,
    M_RD_TGT
  } mRdSel_t;

  function automatic logic [3:0] srcLevel(input int s);
    return 4'((s % 15) + 1);
  endfunction
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              mWe,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic              cWe,
  input  logic [ADDR_W-1:0] cAddr,
  output strobes_t          strb,
  output mRdSel_t           mRdSel,
  output logic              cRdPend
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] mWord;
  logic [WORD_W-1:0] cWord;
  logic              mAligned;
  logic              cAligned;

  assign mWord    = mAddr[ADDR_W-1:2];
  assign cWord    = cAddr[ADDR_W-1:2];
  assign mAligned = (mAddr[1:0] == 2'b00);
  assign cAligned = (cAddr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    if (mWe && mAligned) begin
      case (mWord)
        WORD_W'(2): strb.mEnable  = 1'b1;
        WORD_W'(3): strb.mDisable = 1'b1;
        WORD_W'(4): strb.mTarget  = 1'b1;
        default: ;
      endcase
    end
    if (cWe && cAligned) begin
      case (cWord)
        WORD_W'(1): strb.cClear = 1'b1;
        WORD_W'(2): strb.cSet   = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    mRdSel = M_RD_NONE;
    if (mAligned) begin
      case (mWord)
        WORD_W'(0): mRdSel = M_RD_PEND;
        WORD_W'(1): mRdSel = M_RD_DIS;
        WORD_W'(4): mRdSel = M_RD_TGT;
        default:    mRdSel = M_RD_NONE;
      endcase
    end
  end

  assign cRdPend = cAligned && (cWord == '0);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 20,
  parameter int CPU_W    = $clog2(NUM_CPUS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  mRdSel_t               mRdSel,
  input  logic                  cRdPend,
  input  logic [CPU_W-1:0]      cSel,
  input  logic [31:0]           mWdata,
  input  logic [31:0]           cWdata,
  input  logic [NUM_SRC-1:0]    sysIrq,
  input  logic [NUM_CPUS-1:0]   timerIrq,
  input  logic [NUM_CPUS-1:0]   lvl15Irq,
  output logic [31:0]           mRdata,
  output logic [31:0]           cRdata,
  output logic [NUM_CPUS*15-1:0] irlOut,
  output logic [NUM_SRC-1:0]    sysPendO,
  output logic [31:0]           disO,
  output logic [CPU_W-1:0]      tgtO,
  output logic [NUM_CPUS*32-1:0] cpuPendO
);
  localparam logic [31:0] VALID_MASK =
    32'((64'd1 << NUM_SRC) - 64'd1) | (32'd1 << MDIS_BIT);

  logic [NUM_SRC-1:0]    sysPend;
  logic [31:0]           disReg;
  logic [CPU_W-1:0]      tgtCpu;
  logic [31:0]           cpuPend [NUM_CPUS];
  logic [31:0]           nxtPend [NUM_CPUS];
  logic [VEC_W-1:0]      vec     [NUM_CPUS];
  logic [NUM_SRC-1:0]    livePend;
  logic [NUM_CPUS*15-1:0] irlQ;
  logic [31:0]           mVal;

  assign mVal     = mWdata & VALID_MASK;
  assign livePend = sysPend & ~disReg[NUM_SRC-1:0];

  always_comb begin
    for (int i = 0; i < NUM_CPUS; i++) begin
      nxtPend[i] = cpuPend[i];
      if (cSel == CPU_W'(i)) begin
        if (strb.cClear) nxtPend[i] = nxtPend[i] & ~(cWdata & CLR_MASK);
        if (strb.cSet)   nxtPend[i] = nxtPend[i] | (cWdata & SOFT_MASK);
      end
      if (lvl15Irq[i]) nxtPend[i][LVL15_BIT] = 1'b1;
      nxtPend[i][TIMER_BIT] = timerIrq[i];

      vec[i] = '0;
      if (tgtCpu == CPU_W'(i)) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (livePend[s]) vec[i][srcLevel(s)] = 1'b1;
        end
      end
      if (!disReg[MDIS_BIT]) begin
        vec[i][LVL15_BIT] = vec[i][LVL15_BIT] | cpuPend[i][LVL15_BIT];
        vec[i][TIMER_BIT] = vec[i][TIMER_BIT] | cpuPend[i][TIMER_BIT];
      end
      vec[i] = vec[i] | cpuPend[i][31:16];
      vec[i][0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysPend <= '0;
      disReg  <= '0;
      tgtCpu  <= '0;
      irlQ    <= '0;
      for (int i = 0; i < NUM_CPUS; i++) cpuPend[i] <= '0;
    end else begin
      sysPend <= sysIrq;
      if (strb.mEnable)       disReg <= disReg & ~mVal;
      else if (strb.mDisable) disReg <= disReg | mVal;
      if (strb.mTarget) tgtCpu <= mWdata[CPU_W-1:0];
      for (int i = 0; i < NUM_CPUS; i++) begin
        cpuPend[i] <= nxtPend[i];
        if (irlQ[i*15 +: 15] != vec[i][15:1]) irlQ[i*15 +: 15] <= vec[i][15:1];
      end
    end
  end

  always_comb begin
    case (mRdSel)
      M_RD_PEND: mRdata = 32'(sysPend);
      M_RD_DIS:  mRdata = disReg;
      M_RD_TGT:  mRdata = 32'(tgtCpu);
      default:   mRdata = '0;
    endcase
  end

  assign cRdata = cRdPend ? cpuPend[cSel] : '0;
  assign irlOut = irlQ;

  assign sysPendO = sysPend;
  assign disO     = disReg;
  assign tgtO     = tgtCpu;
  generate
    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_flat
      assign cpuPendO[g*32 +: 32] = cpuPend[g];
    end
  endgenerate
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 20,
  parameter int ADDR_W   = 6,
  parameter int CPU_W    = $clog2(NUM_CPUS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SRC-1:0]     sysIrq,
  input  logic [NUM_CPUS-1:0]    timerIrq,
  input  logic [NUM_CPUS-1:0]    lvl15Irq,
  input  logic                   mWe,
  input  logic [ADDR_W-1:0]      mAddr,
  input  logic [31:0]            mWdata,
  output logic [31:0]            mRdata,
  input  logic                   cWe,
  input  logic [CPU_W-1:0]       cSel,
  input  logic [ADDR_W-1:0]      cAddr,
  input  logic [31:0]            cWdata,
  output logic [31:0]            cRdata,
  output logic [NUM_CPUS*15-1:0] irlOut
);
  strobes_t              strb;
  mRdSel_t               mRdSel;
  logic                  cRdPend;
  logic [NUM_SRC-1:0]    sysPend;
  logic [31:0]           disReg;
  logic [CPU_W-1:0]      tgtCpu;
  logic [NUM_CPUS*32-1:0] cpuPend;

  intc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .mWe(mWe), .mAddr(mAddr), .cWe(cWe), .cAddr(cAddr),
    .strb(strb), .mRdSel(mRdSel), .cRdPend(cRdPend)
  );

  intc_datapath #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .CPU_W(CPU_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mRdSel(mRdSel), .cRdPend(cRdPend),
    .cSel(cSel), .mWdata(mWdata), .cWdata(cWdata), .sysIrq(sysIrq),
    .timerIrq(timerIrq), .lvl15Irq(lvl15Irq), .mRdata(mRdata), .cRdata(cRdata),
    .irlOut(irlOut), .sysPendO(sysPend), .disO(disReg), .tgtO(tgtCpu),
    .cpuPendO(cpuPend)
  );
endmodule

// File: rtl/intc_sva.sv
module intc_sva #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 20,
  parameter int ADDR_W   = 6,
  parameter int CPU_W    = $clog2(NUM_CPUS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_SRC-1:0]     sysIrq,
  input logic [NUM_CPUS-1:0]    timerIrq,
  input logic [NUM_CPUS-1:0]    lvl15Irq,
  input logic                   mWe,
  input logic [ADDR_W-1:0]      mAddr,
  input logic [31:0]            mWdata,
  input logic                   cWe,
  input logic [CPU_W-1:0]       cSel,
  input logic [ADDR_W-1:0]      cAddr,
  input logic [31:0]            cWdata,
  input logic [NUM_SRC-1:0]     sysPend,
  input logic [31:0]            disReg,
  input logic [CPU_W-1:0]       tgtCpu,
  input logic [NUM_CPUS*32-1:0] cpuPend
);
  localparam logic [31:0] VALID =
    32'((64'd1 << NUM_SRC) - 64'd1) | (32'd1 << 31);
  localparam logic [31:0] SOFT = 32'hFFFE_0000;
  localparam logic [31:0] CLRM = 32'hFFFE_8000;

  logic mAl, cAl;
  logic [ADDR_W-3:0] mW, cW;
  assign mAl = (mAddr[1:0] == 2'b00);
  assign cAl = (cAddr[1:0] == 2'b00);
  assign mW  = mAddr[ADDR_W-1:2];
  assign cW  = cAddr[ADDR_W-1:2];

  a_r7_pend_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> sysPend == $past(sysIrq));

  a_r6_target: assert property (@(posedge clk) disable iff (!rstN)
    (mWe && mAl && mW == 4) |=> tgtCpu == $past(mWdata[CPU_W-1:0]));

  a_r4_enable: assert property (@(posedge clk) disable iff (!rstN)
    (mWe && mAl && mW == 2) |=> (disReg & $past(mWdata) & VALID) == 32'd0);

  a_r5_disable: assert property (@(posedge clk) disable iff (!rstN)
    (mWe && mAl && mW == 3) |=>
      (disReg & $past(mWdata) & VALID) == ($past(mWdata) & VALID));

  a_r12_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mWe && (!mAl || (mW != 2 && mW != 3 && mW != 4))) |=>
      ($stable(disReg) && $stable(tgtCpu)));

  generate
    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
      a_r10_timer: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> cpuPend[i*32+14] == $past(timerIrq[i]));

      a_r3_set: assert property (@(posedge clk) disable iff (!rstN)
        (cWe && cAl && cW == 2 && cSel == CPU_W'(i)) |=>
          (cpuPend[i*32 +: 32] & $past(cWdata) & SOFT) == ($past(cWdata) & SOFT));

      a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
        (cWe && cAl && cW == 1 && cSel == CPU_W'(i) && !lvl15Irq[i]) |=>
          (cpuPend[i*32 +: 32] & $past(cWdata) & CLRM) == 32'd0);
    end
  endgenerate
endmodule

bind intc_top intc_sva #(
  .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
) sva_i (
  .clk(clk), .rstN(rstN), .sysIrq(sysIrq), .timerIrq(timerIrq),
  .lvl15Irq(lvl15Irq), .mWe(mWe), .mAddr(mAddr), .mWdata(mWdata),
  .cWe(cWe), .cSel(cSel), .cAddr(cAddr), .cWdata(cWdata),
  .sysPend(sysPend), .disReg(disReg), .tgtCpu(tgtCpu), .cpuPend(cpuPend)
);

// File: tb/intc_tb_top.sv
module intc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int NSRC = 20;
  localparam int AW   = 6;
  localparam int CW   = 2;
  localparam logic [31:0] VALID = 32'h000F_FFFF | 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] sysIrq = '0;
  logic [NCPU-1:0] timerIrq = '0;
  logic [NCPU-1:0] lvl15Irq = '0;
  logic mWe = 1'b0;
  logic [AW-1:0] mAddr = '0;
  logic [31:0] mWdata = '0;
  logic [31:0] mRdata;
  logic cWe = 1'b0;
  logic [CW-1:0] cSel = '0;
  logic [AW-1:0] cAddr = '0;
  logic [31:0] cWdata = '0;
  logic [31:0] cRdata;
  logic [NCPU*15-1:0] irlOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  logic [31:0] disM = '0;
  logic [1:0]  tgtM = '0;
  logic [31:0] cPendM [NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top #(.NUM_CPUS(NCPU), .NUM_SRC(NSRC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .sysIrq(sysIrq), .timerIrq(timerIrq),
    .lvl15Irq(lvl15Irq), .mWe(mWe), .mAddr(mAddr), .mWdata(mWdata),
    .mRdata(mRdata), .cWe(cWe), .cSel(cSel), .cAddr(cAddr),
    .cWdata(cWdata), .cRdata(cRdata), .irlOut(irlOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NCPU*15-1:0] expIrl();
    logic [NCPU*15-1:0] r = '0;
    for (int c = 0; c < NCPU; c++) begin
      logic [15:0] v = '0;
      if (tgtM == 2'(c))
        for (int s = 0; s < NSRC; s++)
          if (sysIrq[s] && !disM[s]) v[(s % 15) + 1] = 1'b1;
      if (!disM[31]) v = v | (cPendM[c][15:0] & 16'hC000);
      v = v | cPendM[c][31:16];
      r[c*15 +: 15] = v[15:1];
    end
    return r;
  endfunction

  task automatic mWr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    mWe = 1'b1; mAddr = a; mWdata = d;
    @(negedge clk);
    mWe = 1'b0;
    if (a[1:0] == 2'b00) begin
      case (a >> 2)
        2: disM = disM & ~(d & VALID);
        3: disM = disM | (d & VALID);
        4: tgtM = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic cWr(input int c, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cWe = 1'b1; cSel = 2'(c); cAddr = a; cWdata = d;
    @(negedge clk);
    cWe = 1'b0;
    if (a == 4) cPendM[c] = cPendM[c] & ~(d & 32'hFFFE_8000);
    if (a == 8) cPendM[c] = cPendM[c] | (d & 32'hFFFE_0000);
  endtask

  task automatic mRd(input logic [AW-1:0] a, output logic [31:0] d);
    mAddr = a; #1; d = mRdata;
  endtask

  task automatic cRd(input int c, output logic [31:0] d);
    cSel = 2'(c); cAddr = '0; #1; d = cRdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int c = 0; c < NCPU; c++) cPendM[c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irl", 64'(irlOut), 64'd0);
    mRd(0, rd); check("R1 pend", 64'(rd), 0);
    mRd(4, rd); check("R1 dis", 64'(rd), 0);
    mRd(16, rd); check("R1 tgt", 64'(rd), 0);
    cRd(2, rd); check("R1 cpu pend", 64'(rd), 0);
    rstN = 1'b1;
    settle();
    check("R1 irl after release", 64'(irlOut), 64'd0);

    // R6 target masking
    for (int v = 0; v < 8; v++) begin
      mWr(16, 32'(v) | 32'h0000_FF00);
      mRd(16, rd); check("R6 target", 64'(rd), 64'(v & 3));
    end

    // R7 routing sweep over every source and target
    mWr(8, 32'hFFFF_FFFF);
    for (int t = 0; t < NCPU; t++) begin
      mWr(16, 32'(t));
      for (int s = 0; s < NSRC; s++) begin
        @(negedge clk); sysIrq = NSRC'(1) << s;
        settle();
        check("R7 route", 64'(irlOut), 64'(expIrl()));
        mRd(0, rd); check("R7 pend", 64'(rd), 64'(sysIrq));
      end
    end

    // R11 output latency: one clock for pending, one for output
    @(negedge clk); sysIrq = NSRC'(1) << 6;
    @(negedge clk);
    check("R11 not yet", 64'(irlOut), 64'(NCPU*15 == 60 ? (64'd1 << (3*15 + 4)) : 0));
    @(negedge clk);
    check("R11 updated", 64'(irlOut), 64'(expIrl()));

    // R5 / R4 disable keeps pending
    @(negedge clk); sysIrq = '1;
    mWr(12, 32'h5555_5555);
    settle();
    mRd(0, rd); check("R5 pend kept", 64'(rd), 64'h000F_FFFF);
    mRd(4, rd); check("R5 dis masked", 64'(rd), 64'(32'h5555_5555 & VALID));
    check("R5 irl", 64'(irlOut), 64'(expIrl()));
    mWr(12, 32'hFFFF_FFFF);
    mRd(4, rd); check("R5 dis all", 64'(rd), 64'(VALID));
    settle();
    check("R5 irl masked", 64'(irlOut), 64'(expIrl()));
    mWr(8, 32'h000A_AAAA);
    mRd(4, rd); check("R4 partial enable", 64'(rd), 64'(VALID & ~32'h000A_AAAA));
    settle();
    check("R4 irl", 64'(irlOut), 64'(expIrl()));
    mWr(8, 32'hFFFF_FFFF);
    mRd(4, rd); check("R4 all enabled", 64'(rd), 0);
    @(negedge clk); sysIrq = '0;
    settle();

    // R9 / R3 / R2 software bit sweep
    for (int c = 0; c < NCPU; c++) begin
      for (int b = 17; b < 32; b++) begin
        cWr(c, 8, 32'd1 << b);
        cRd(c, rd); check("R3 set", 64'(rd), 64'(32'd1 << b));
        settle();
        check("R9 level", 64'(irlOut), 64'(expIrl()));
        cWr(c, 4, 32'd1 << b);
        cRd(c, rd); check("R2 clear", 64'(rd), 0);
      end
      cWr(c, 8, 32'h0001_FFFF);
      settle();
      cRd(c, rd); check("R3 non-soft ignored", 64'(rd), 0);
      check("R3 irl", 64'(irlOut), 64'd0);
    end

    // R10 / R8 timer and level-15
    @(negedge clk); timerIrq = 4'b0100;
    settle();
    cRd(2, rd); check("R10 timer pend", 64'(rd), 64'h4000);
    check("R8 timer level", 64'(irlOut), 64'd1 << (2*15 + 13));
    cPendM[2][14] = 1'b1;
    cWr(2, 4, 32'hFFFF_FFFF);
    cRd(2, rd); check("R2 timer kept", 64'(rd), 64'h4000);
    @(negedge clk); lvl15Irq = 4'b0010;
    @(negedge clk); lvl15Irq = 4'b0000;
    cPendM[1][15] = 1'b1;
    settle();
    cRd(1, rd); check("R10 lvl15 sticky", 64'(rd), 64'h8000);
    check("R8 lvl15 level", 64'(irlOut), 64'(expIrl()));
    mWr(12, 32'h8000_0000);
    settle();
    check("R8 master disable", 64'(irlOut), 64'd0);
    cRd(1, rd); check("R8 pend kept", 64'(rd), 64'h8000);
    mWr(8, 32'h8000_0000);
    settle();
    check("R8 re-enabled", 64'(irlOut), 64'(expIrl()));
    @(negedge clk); cWe = 1'b1; cSel = 2'd1; cAddr = 4; cWdata = 32'h8000; lvl15Irq = 4'b0010;
    @(negedge clk); cWe = 1'b0; lvl15Irq = 4'b0000;
    cRd(1, rd); check("R10 set beats clear", 64'(rd), 64'h8000);
    cWr(1, 4, 32'h8000);
    cRd(1, rd); check("R2 lvl15 cleared", 64'(rd), 0);
    @(negedge clk); timerIrq = '0;
    cPendM[2][14] = 1'b0;
    settle();
    cRd(2, rd); check("R10 timer follows", 64'(rd), 0);
    check("R11 all low", 64'(irlOut), 64'd0);

    // R12 ignored writes
    mWr(16, 32'd3);
    mWr(12, 32'h0000_0003);
    mWr(0, 32'hFFFF_FFFF);
    mWr(4, 32'hFFFF_FFFF);
    mWr(20, 32'hFFFF_FFFF);
    mWr(17, 32'd1);
    mWr(9, 32'hFFFF_FFFF);
    mRd(16, rd); check("R12 target kept", 64'(rd), 3);
    mRd(4, rd); check("R12 dis kept", 64'(rd), 3);
    cWr(0, 9, 32'hFFFF_FFFF);
    cWr(0, 0, 32'hFFFF_FFFF);
    cRd(0, rd); check("R12 cpu kept", 64'(rd), 0);
    mWr(8, 32'hFFFF_FFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule